// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block sits in a memory controller and takes a DDR3-class device into self-refresh and back out again. A request from the refresh or power logic is held until the device can safely enter: all banks idle, the precharge interval over, no burst on the data bus and, when termination is configured, the ODT pin already low. Entry is one REFRESH command issued in the same cycle that CKE goes low. It is followed by a single NOP, and then deselects for as long as CKE stays low.

The memory clock may optionally be stopped while the device sleeps. The clock stays running for a programmed number of cycles after entry before it stops, and is restored a programmed number of cycles before CKE rises. Exit is a wake request that raises CKE. From that edge, two grant flags release the command bus in two steps: first for commands that do not need a locked DLL, later for commands that do. All intervals are cycle counts. They are captured from configuration inputs only while the sequencer is idle.

Top module: `selfref_seq`

## Requirements
- R1: During and straight after reset (synchronous, active low) the outputs are CKE high, ODT low, command NOP (code 0), clock-stop low and both grant flags high.
- R2: A self-refresh request is kept pending while any bank is busy or a burst is active. One cycle after the first cycle in which it is pending and every condition holds, the command is REF (code 2) with CKE low. With all conditions already met, REF comes two cycles after the request pulse.
- R3: After a precharge marker pulse, entry waits out `cfg_trp` cycles. With the request given in the same cycle as the marker, REF comes exactly `cfg_trp`+2 cycles after it.
- R4: With termination enabled, ODT is forced low from the cycle after the request, and REF is only issued after ODT has been low for at least one cycle. With termination disabled, ODT keeps following `odt_in` until entry. ODT is low throughout self-refresh.
- R5: The cycle after REF carries NOP with CKE low. Every later cycle with CKE low carries DES (code 1).
- R6: CKE stays low for at least `cfg_tckesr` cycles. A wake request that arrives early is deferred, so CKE is then low for exactly `cfg_tckesr` cycles (for values of 3 or more, clock stop off).
- R7: A wake request that arrives after the minimum low time raises CKE two cycles after the wake pulse (clock stop off).
- R8: With clock stop enabled, the clock-stop output first rises exactly `cfg_tcksre` cycles after the REF cycle (for values of 3 or more).
- R9: CKE never rises while the clock is stopped. The clock-stop output falls exactly `max(cfg_tcksrx,1)` cycles before CKE rises.
- R10: Both grant flags are low from REF until CKE is high again. Counting the first cycle with CKE high as cycle 0, the non-DLL flag rises in cycle `max(cfg_txs,1)` and the DLL flag rises in cycle `max(cfg_txsdll, max(cfg_txs,1))`. The DLL flag is never high while the other is low.
- R11: While the DLL flag is still low after exit, the command is NOP.
- R12: Timing inputs are captured only while idle. A change made during self-refresh does not alter the current exit.
- R13: A wake request while idle is ignored and not remembered. A self-refresh request during self-refresh or exit is ignored and causes no new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sr_req | input | 1 | Self-refresh request pulse |
| wake_req | input | 1 | Wake request pulse |
| banks_idle | input | 1 | All banks precharged and idle |
| burst_active | input | 1 | A data burst is in progress |
| prech_evt | input | 1 | Pulse marking a precharge command |
| term_en | input | 1 | Some on-die termination is enabled in configuration |
| odt_in | input | 1 | ODT value wanted by normal traffic |
| cfg_trp | input | TW | Precharge wait, cycles |
| cfg_tckesr | input | TW | Minimum CKE-low time, cycles |
| cfg_tcksre | input | TW | Clock-stable time after entry, cycles |
| cfg_tcksrx | input | TW | Clock-stable time before exit, cycles |
| cfg_txs | input | TW | Exit wait for non-DLL commands, cycles |
| cfg_txsdll | input | TW | Exit wait for DLL commands, cycles |
| cfg_clkstop_en | input | 1 | Stop the memory clock during self-refresh |
| mem_cke | output | 1 | Clock enable to the device |
| mem_odt | output | 1 | ODT pin to the device |
| mem_cmd | output | 2 | Command: 0 NOP, 1 DES, 2 REF |
| mem_clk_stop | output | 1 | Gate the memory clock off |
| grant_nodll | output | 1 | Commands without a DLL dependency may issue |
| grant_dll | output | 1 | DLL-dependent commands may issue |

## Verification
The hardest state to reach is a wake request that lands while the clock is stopped, or before the minimum CKE-low time has run out, so that it has to be remembered and acted on later. The bench reaches it by pulsing wake in the very cycle that REF appears, with long low-time and clock-stable settings. It then measures the exact cycle of each clock-stop edge and of the CKE rise. It also gives a late wake in a separate run, changes timing inputs in the middle of self-refresh, and feeds grant settings with zero or inverted values to exercise their normalisation.

// File: rtl/selfref_pkg.sv
package selfref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_POST,
    ST_HOLD,
    ST_CLKOFF,
    ST_CLKON,
    ST_EXIT
  } sr_state_e;

  localparam logic [1:0] CMD_NOP = 2'd0;
  localparam logic [1:0] CMD_DES = 2'd1;
  localparam logic [1:0] CMD_REF = 2'd2;

  // larger of two counts
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // true when the cycles already spent plus the current one cover the need
  function automatic logic span_done(input int unsigned spent, input int unsigned need);
    return (spent + 1) >= need;
  endfunction

endpackage

// File: rtl/sr_sat_cnt.sv
module sr_sat_cnt #(
  parameter int W          = 9,
  parameter bit START_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= START_FULL ? TOP : '0;
    else if (clr)             cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/sr_cfg_hold.sv
module sr_cfg_hold
  import selfref_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] cfg_trp,
  input  logic [TW-1:0] cfg_tckesr,
  input  logic [TW-1:0] cfg_tcksre,
  input  logic [TW-1:0] cfg_tcksrx,
  input  logic [TW-1:0] cfg_txs,
  input  logic [TW-1:0] cfg_txsdll,
  input  logic          cfg_clkstop_en,
  output logic [TW-1:0] trp_q,
  output logic [TW-1:0] tckesr_q,
  output logic [TW-1:0] tcksre_q,
  output logic [TW-1:0] tcksrx_q,
  output logic [TW-1:0] txs_q,
  output logic [TW-1:0] txsdll_q,
  output logic          clkstop_q
);
  logic [TW-1:0] txs_n, txsdll_n, tcksrx_n;

  // exit waits of zero are raised to one; the DLL wait never ends first
  always_comb begin
    txs_n    = TW'(max_u(32'(cfg_txs), 32'd1));
    txsdll_n = TW'(max_u(32'(cfg_txsdll), 32'(txs_n)));
    tcksrx_n = TW'(max_u(32'(cfg_tcksrx), 32'd1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trp_q     <= '0;
      tckesr_q  <= '0;
      tcksre_q  <= '0;
      tcksrx_q  <= TW'(1);
      txs_q     <= TW'(1);
      txsdll_q  <= TW'(1);
      clkstop_q <= 1'b0;
    end else if (load) begin
      trp_q     <= cfg_trp;
      tckesr_q  <= cfg_tckesr;
      tcksre_q  <= cfg_tcksre;
      tcksrx_q  <= tcksrx_n;
      txs_q     <= txs_n;
      txsdll_q  <= txsdll_n;
      clkstop_q <= cfg_clkstop_en;
    end
  end
endmodule

// File: rtl/sr_entry_gate.sv
module sr_entry_gate #(
  parameter int TW = 8,
  parameter int CW = TW + 1
) (
  input  logic          pend,
  input  logic          banks_idle,
  input  logic          burst_active,
  input  logic [CW-1:0] rp_cnt,
  input  logic [TW-1:0] trp,
  input  logic          term_en,
  input  logic          odt_now,
  output logic          rp_ok,
  output logic          go
);
  assign rp_ok = rp_cnt >= {{(CW-TW){1'b0}}, trp};
  assign go    = pend && banks_idle && !burst_active && rp_ok && (!term_en || !odt_now);
endmodule

// File: rtl/selfref_seq.sv
module selfref_seq
  import selfref_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_req,
  input  logic          wake_req,
  input  logic          banks_idle,
  input  logic          burst_active,
  input  logic          prech_evt,
  input  logic          term_en,
  input  logic          odt_in,
  input  logic [TW-1:0] cfg_trp,
  input  logic [TW-1:0] cfg_tckesr,
  input  logic [TW-1:0] cfg_tcksre,
  input  logic [TW-1:0] cfg_tcksrx,
  input  logic [TW-1:0] cfg_txs,
  input  logic [TW-1:0] cfg_txsdll,
  input  logic          cfg_clkstop_en,
  output logic          mem_cke,
  output logic          mem_odt,
  output logic [1:0]    mem_cmd,
  output logic          mem_clk_stop,
  output logic          grant_nodll,
  output logic          grant_dll
);
  localparam int CW = TW + 1;

  sr_state_e     state_q, state_n;
  logic          pend_q, wake_q;
  logic [TW-1:0] trp_q, tckesr_q, tcksre_q, tcksrx_q, txs_q, txsdll_q;
  logic          clkstop_q;
  logic [CW-1:0] rp_cnt, low_cnt, ph_cnt;

  // named internal events
  logic entry_go, rp_ok, ckesr_met, cksre_met, cksrx_met, xs_met, xsdll_met;
  logic in_idle, in_exit, asleep, phase_change;

  assign in_idle      = (state_q == ST_IDLE);
  assign in_exit      = (state_q == ST_EXIT);
  assign asleep       = !(in_idle || in_exit);
  assign phase_change = (state_n != state_q);

  sr_cfg_hold #(.TW(TW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(in_idle),
    .cfg_trp(cfg_trp), .cfg_tckesr(cfg_tckesr), .cfg_tcksre(cfg_tcksre),
    .cfg_tcksrx(cfg_tcksrx), .cfg_txs(cfg_txs), .cfg_txsdll(cfg_txsdll),
    .cfg_clkstop_en(cfg_clkstop_en),
    .trp_q(trp_q), .tckesr_q(tckesr_q), .tcksre_q(tcksre_q),
    .tcksrx_q(tcksrx_q), .txs_q(txs_q), .txsdll_q(txsdll_q),
    .clkstop_q(clkstop_q)
  );

  // cycles since the last precharge marker
  sr_sat_cnt #(.W(CW), .START_FULL(1'b1)) u_rp_cnt (
    .clk(clk), .rst_n(rst_n), .clr(prech_evt), .inc(1'b1), .cnt(rp_cnt)
  );

  // cycles CKE has already spent low
  sr_sat_cnt #(.W(CW), .START_FULL(1'b0)) u_low_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!asleep), .inc(1'b1), .cnt(low_cnt)
  );

  // cycles spent in the current phase
  sr_sat_cnt #(.W(CW), .START_FULL(1'b0)) u_ph_cnt (
    .clk(clk), .rst_n(rst_n), .clr(phase_change), .inc(1'b1), .cnt(ph_cnt)
  );

  sr_entry_gate #(.TW(TW), .CW(CW)) u_gate (
    .pend(pend_q), .banks_idle(banks_idle), .burst_active(burst_active),
    .rp_cnt(rp_cnt), .trp(trp_q), .term_en(term_en), .odt_now(mem_odt),
    .rp_ok(rp_ok), .go(entry_go)
  );

  assign ckesr_met = span_done(32'(low_cnt), 32'(tckesr_q));
  assign cksre_met = span_done(32'(low_cnt), 32'(tcksre_q));
  assign cksrx_met = span_done(32'(ph_cnt), 32'(tcksrx_q));
  assign xs_met    = ph_cnt >= {1'b0, txs_q};
  assign xsdll_met = ph_cnt >= {1'b0, txsdll_q};

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:   if (entry_go) state_n = ST_ENTER;
      ST_ENTER:  state_n = ST_POST;
      ST_POST:   state_n = ST_HOLD;
      ST_HOLD: begin
        if (clkstop_q) begin
          if (cksre_met) state_n = ST_CLKOFF;
        end else if (wake_q && ckesr_met) begin
          state_n = ST_EXIT;
        end
      end
      ST_CLKOFF: if (wake_q && ckesr_met) state_n = ST_CLKON;
      ST_CLKON:  if (cksrx_met) state_n = ST_EXIT;
      ST_EXIT:   if (xsdll_met) state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (in_idle) pend_q <= entry_go ? 1'b0 : (pend_q || sr_req);
      if (state_q inside {ST_ENTER, ST_POST, ST_HOLD, ST_CLKOFF})
        wake_q <= wake_q || wake_req;
      else
        wake_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ENTER:                      mem_cmd = CMD_REF;
      ST_HOLD, ST_CLKOFF, ST_CLKON:  mem_cmd = CMD_DES;
      default:                       mem_cmd = CMD_NOP;
    endcase
  end

  assign mem_cke      = !asleep;
  assign mem_clk_stop = (state_q == ST_CLKOFF);
  assign mem_odt      = in_idle && odt_in && !(pend_q && term_en);
  assign grant_nodll  = in_idle || (in_exit && xs_met);
  assign grant_dll    = in_idle || (in_exit && xsdll_met);

endmodule

// File: rtl/selfref_seq_chk.sv
module selfref_seq_chk
  import selfref_pkg::*;
#(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_cke,
  input logic          mem_odt,
  input logic [1:0]    mem_cmd,
  input logic          mem_clk_stop,
  input logic          grant_nodll,
  input logic          grant_dll,
  input logic          term_en,
  input logic [TW-1:0] tckesr_q
);
  localparam int LW = TW + 1;
  localparam logic [LW-1:0] LTOP = '1;

  // consecutive cycles CKE has been seen low, counted here independently
  logic [LW-1:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n)              low_run <= '0;
    else if (mem_cke)        low_run <= '0;
    else if (low_run != LTOP) low_run <= low_run + LW'(1);
  end

  p_ref_cke_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_REF) |-> !mem_cke);

  p_odt_off_before_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_cmd == CMD_REF) && $past(term_en)) |-> $past(!mem_odt));

  p_nop_follows_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_REF) |=> ((mem_cmd == CMD_NOP) && !mem_cke));

  p_cke_low_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> (low_run >= {1'b0, tckesr_q}));

  p_clk_back_before_cke_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> !$past(mem_clk_stop));

  p_grants_low_in_sr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cke || mem_clk_stop) |-> (!grant_nodll && !grant_dll));

  p_grant_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_dll |-> grant_nodll);

endmodule

bind selfref_seq selfref_seq_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cke(mem_cke), .mem_odt(mem_odt),
  .mem_cmd(mem_cmd), .mem_clk_stop(mem_clk_stop), .grant_nodll(grant_nodll),
  .grant_dll(grant_dll), .term_en(term_en), .tckesr_q(tckesr_q)
);

// File: tb/test_selfref_seq.sv
module test_selfref_seq;
  import selfref_pkg::*;

  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_req = 0, wake_req = 0, banks_idle = 1, burst_active = 0, prech_evt = 0;
  logic term_en = 0, odt_in = 0, cfg_clkstop_en = 0;
  logic [TW-1:0] cfg_trp = 0, cfg_tckesr = 3, cfg_tcksre = 0, cfg_tcksrx = 1;
  logic [TW-1:0] cfg_txs = 1, cfg_txsdll = 1;
  logic mem_cke, mem_odt, mem_clk_stop, grant_nodll, grant_dll;
  logic [1:0] mem_cmd;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  selfref_seq #(.TW(TW)) i_selfref_seq (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .wake_req(wake_req),
    .banks_idle(banks_idle), .burst_active(burst_active), .prech_evt(prech_evt),
    .term_en(term_en), .odt_in(odt_in),
    .cfg_trp(cfg_trp), .cfg_tckesr(cfg_tckesr), .cfg_tcksre(cfg_tcksre),
    .cfg_tcksrx(cfg_tcksrx), .cfg_txs(cfg_txs), .cfg_txsdll(cfg_txsdll),
    .cfg_clkstop_en(cfg_clkstop_en),
    .mem_cke(mem_cke), .mem_odt(mem_odt), .mem_cmd(mem_cmd),
    .mem_clk_stop(mem_clk_stop), .grant_nodll(grant_nodll), .grant_dll(grant_dll)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int trp, input int ckesr, input int cksre, input int cksrx,
                         input int xs, input int xsdll, input bit stop);
    cfg_trp = TW'(trp); cfg_tckesr = TW'(ckesr); cfg_tcksre = TW'(cksre);
    cfg_tcksrx = TW'(cksrx); cfg_txs = TW'(xs); cfg_txsdll = TW'(xsdll);
    cfg_clkstop_en = stop;
    tick(); tick();
  endtask

  // pulse a request and return the number of cycles until REF is seen
  task automatic enter_sr(output int lat);
    lat = -1;
    sr_req = 1;
    for (int i = 1; i <= 60; i++) begin
      tick();
      sr_req = 0;
      if (mem_cmd == CMD_REF) begin lat = i; break; end
    end
  endtask

  // pulse wake and stop in the first cycle with CKE high
  task automatic wake_to_cke;
    wake_req = 1;
    for (int i = 0; i < 300; i++) begin
      tick();
      wake_req = 0;
      if (mem_cke) break;
    end
  endtask

  task automatic finish_exit;
    wake_to_cke();
    for (int i = 0; i < 300; i++) begin
      if (grant_dll) break;
      tick();
    end
    tick();
  endtask

  // called in the first cycle with CKE high (cycle 0)
  task automatic measure_grants(output int fn, output int fd, output int badcmd);
    fn = -1; fd = -1; badcmd = 0;
    for (int j = 0; j <= 300; j++) begin
      if (j > 0) tick();
      if (fn < 0 && grant_nodll) fn = j;
      if (fd < 0 && grant_dll) fd = j;
      if (!grant_dll && mem_cmd != CMD_NOP) badcmd++;
      if (fd >= 0) break;
    end
  endtask

  task automatic t_reset;
    // R1: values while reset is held and after release
    chk("R1", "cke in reset", int'(mem_cke), 1);
    chk("R1", "cmd in reset", int'(mem_cmd), int'(CMD_NOP));
    chk("R1", "odt in reset", int'(mem_odt), 0);
    chk("R1", "clk_stop in reset", int'(mem_clk_stop), 0);
    chk("R1", "grants in reset", int'({grant_nodll, grant_dll}), 3);
    rst_n = 1;
    tick();
    chk("R1", "cke after reset", int'(mem_cke), 1);
  endtask

  task automatic t_basic;
    int lat, low, gsr, fn, fd, badcmd;
    set_cfg(0, 10, 0, 1, 3, 7, 0);
    enter_sr(lat);
    chk("R2", "entry latency", lat, 2);
    cfg_txs = 9; cfg_txsdll = 2;          // R12: late change must not apply
    wake_req = 1;                          // early wake, deferred (R6)
    gsr = int'(grant_nodll) + int'(grant_dll);
    low = 1;
    tick(); wake_req = 0;
    chk("R5", "cmd after REF", int'(mem_cmd), int'(CMD_NOP));
    chk("R5", "cke after REF", int'(mem_cke), 0);
    low++;
    tick();
    chk("R5", "cmd in sleep", int'(mem_cmd), int'(CMD_DES));
    low++;
    for (int i = 0; i < 100; i++) begin
      tick();
      if (mem_cke) break;
      low++;
      gsr += int'(grant_nodll) + int'(grant_dll);
    end
    chk("R6", "cke low cycles with early wake", low, 10);
    chk("R10", "grants seen during sleep", gsr, 0);
    measure_grants(fn, fd, badcmd);
    chk("R10", "non-DLL grant cycle", fn, 3);
    chk("R12", "DLL grant cycle with config changed in sleep", fd, 7);
    chk("R11", "non-NOP commands before DLL grant", badcmd, 0);
    tick();
  endtask

  task automatic t_pending;
    int seen;
    set_cfg(0, 3, 0, 1, 1, 1, 0);
    banks_idle = 0;
    sr_req = 1; tick(); sr_req = 0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (mem_cmd == CMD_REF || !mem_cke) seen++;
    end
    chk("R2", "entry while banks busy", seen, 0);
    banks_idle = 1;
    tick();
    chk("R2", "REF one cycle after banks idle", int'(mem_cmd), int'(CMD_REF));
    finish_exit();
    burst_active = 1;
    sr_req = 1; tick(); sr_req = 0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (mem_cmd == CMD_REF || !mem_cke) seen++;
    end
    chk("R2", "entry during burst", seen, 0);
    burst_active = 0;
    tick();
    chk("R2", "REF one cycle after burst ends", int'(mem_cmd), int'(CMD_REF));
    finish_exit();
  endtask

  task automatic t_trp;
    int lat;
    set_cfg(5, 3, 0, 1, 1, 1, 0);
    prech_evt = 1;
    sr_req = 1;
    lat = -1;
    for (int i = 1; i <= 40; i++) begin
      tick();
      prech_evt = 0; sr_req = 0;
      if (mem_cmd == CMD_REF) begin lat = i; break; end
    end
    chk("R3", "REF after precharge marker", lat, 7);
    finish_exit();
  endtask

  task automatic t_odt;
    set_cfg(0, 3, 0, 1, 1, 1, 0);
    term_en = 1; odt_in = 1;
    tick();
    chk("R4", "odt follows input when idle", int'(mem_odt), 1);
    sr_req = 1; tick(); sr_req = 0;
    chk("R4", "odt forced low after request", int'(mem_odt), 0);
    chk("R4", "no REF while odt just dropped", int'(mem_cmd), int'(CMD_NOP));
    tick();
    chk("R4", "REF after odt low", int'(mem_cmd), int'(CMD_REF));
    finish_exit();
    term_en = 0;
    sr_req = 1; tick(); sr_req = 0;
    chk("R4", "odt kept when termination off", int'(mem_odt), 1);
    tick();
    chk("R4", "REF with termination off", int'(mem_cmd), int'(CMD_REF));
    chk("R4", "odt low in sleep", int'(mem_odt), 0);
    finish_exit();
    odt_in = 0;
  endtask

  task automatic t_clkstop;
    int lat, first_stop, stop_end, cke_up, gsr, fn, fd, badcmd;
    set_cfg(0, 3, 6, 4, 2, 2, 1);
    enter_sr(lat);
    wake_req = 1;
    first_stop = -1; stop_end = -1; cke_up = -1; gsr = 0;
    for (int i = 1; i <= 60; i++) begin
      tick();
      wake_req = 0;
      if (first_stop < 0 && mem_clk_stop) first_stop = i;
      if (first_stop >= 0 && stop_end < 0 && !mem_clk_stop) stop_end = i;
      if (mem_clk_stop || !mem_cke) gsr += int'(grant_nodll) + int'(grant_dll);
      if (mem_cke) begin cke_up = i; break; end
    end
    chk("R8", "clock stop start after REF", first_stop, 6);
    chk("R9", "clock restored after REF", stop_end, 7);
    chk("R9", "cycles from clock restore to cke", cke_up - stop_end, 4);
    chk("R10", "grants during clock stop", gsr, 0);
    measure_grants(fn, fd, badcmd);
    chk("R10", "grant after clock-stop exit", fd, 2);
    tick();
  endtask

  task automatic t_late_wake;
    int lat, hi;
    set_cfg(0, 4, 0, 1, 1, 1, 0);
    wake_req = 1; tick(); wake_req = 0; tick();   // R13: wake in idle
    enter_sr(lat);
    hi = 0;
    for (int i = 1; i <= 20; i++) begin
      tick();
      sr_req = (i == 5);                           // R13: request while asleep
      if (mem_cke) hi++;
    end
    sr_req = 0;
    chk("R13", "cke high cycles after idle wake", hi, 0);
    wake_req = 1; tick(); wake_req = 0;
    chk("R7", "cke one cycle after late wake", int'(mem_cke), 0);
    tick();
    chk("R7", "cke two cycles after late wake", int'(mem_cke), 1);
    for (int i = 0; i < 20; i++) begin
      if (grant_dll) break;
      tick();
    end
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (!mem_cke || mem_cmd == CMD_REF) hi++;
    end
    chk("R13", "re-entry from request given while asleep", hi, 0);
  endtask

  task automatic t_norm;
    int lat, fn, fd, badcmd;
    set_cfg(0, 3, 0, 1, 5, 2, 0);
    enter_sr(lat);
    wake_to_cke();
    measure_grants(fn, fd, badcmd);
    chk("R10", "non-DLL grant with short DLL wait", fn, 5);
    chk("R10", "DLL grant raised to non-DLL wait", fd, 5);
    tick();
    set_cfg(0, 3, 0, 1, 0, 0, 0);
    enter_sr(lat);
    wake_to_cke();
    measure_grants(fn, fd, badcmd);
    chk("R10", "non-DLL grant with zero wait", fn, 1);
    chk("R10", "DLL grant with zero wait", fd, 1);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    t_basic();
    t_pending();
    t_trp();
    t_odt();
    t_clkstop();
    t_late_wake();
    t_norm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule